// File: doc/BRIEF.md
# Double-Precision Compare Flag Unit

This block orders two packed binary64 words, called the left operand and the right operand. It returns the outcome as a four-bit condition code (N, Z, C, V) and an invalid-operation flag. It works from the raw bit patterns and does no arithmetic. NaNs are detected from the exponent and fraction fields. Zeros of either sign count as equal. Words that are not NaNs are ordered by sign and then by unsigned magnitude. This ordering also places the infinities correctly.

Two control inputs select the variant. The first makes quiet NaNs raise the invalid flag as well as signalling ones. The second makes the block ignore the right operand and compare against +0.0. A strobe captures the operands, and the result is held in a register until the next strobe. A one-cycle valid pulse marks each new result. The exponent and fraction widths are parameters, so the same logic can be built for a narrow format.

Top module: `fcmp_flag_unit`

## Requirements
- R1: A word is a NaN when its exponent field is all ones and its fraction field is nonzero. If either operand is a NaN, the result is unordered: C=1, V=1, N=0, Z=0.
- R2: The invalid flag is raised for a NaN operand whose most significant fraction bit is 0 (a signalling NaN).
- R3: When `sig_qnan`=1, any NaN operand raises the invalid flag. Without a NaN operand the invalid flag is always 0.
- R4: Without NaNs, the operands are equal when their bit patterns match or when both are zero apart from the sign bit. Equal sets Z=1 and C=1, with N=0 and V=0.
- R5: Without NaNs and with different sign bits (bit 63 = 1 means negative), the negative operand is the smaller one unless both are zero. Left smaller gives N=1 only. Left larger gives C=1 only.
- R6: Without NaNs and with equal sign bits, the 63-bit magnitude fields are compared as unsigned integers. The sense is reversed when both are negative. Infinities are ordered through this comparison.
- R7: When `cmp_zero`=1, +0.0 (all bits zero) replaces the right operand, and the value on `opd_b` has no effect on the result.
- R8: Flags change only on the rising edge that samples `in_valid`=1. `out_valid` is high for exactly the cycle after each strobe. Without a strobe, the flags hold their value.
- R9: While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Strobe that captures the operands |
| opd_a | input | 1+EXP_W+MAN_W (64) | Left operand |
| opd_b | input | 1+EXP_W+MAN_W (64) | Right operand |
| sig_qnan | input | 1 | Quiet NaNs also raise the invalid flag |
| cmp_zero | input | 1 | Compare the left operand against +0.0 |
| out_valid | output | 1 | One-cycle pulse with each new result |
| flag_n | output | 1 | Left operand smaller |
| flag_z | output | 1 | Operands equal |
| flag_c | output | 1 | Greater, equal or unordered |
| flag_v | output | 1 | Unordered |
| inv_op | output | 1 | Invalid-operation flag |

## Verification
There is one register stage, so every result is due on the first rising edge after the strobe, and the valid pulse is due in that same cycle. The bench drives each stimulus on a falling edge and lets one rising edge pass. It then reads all five flags and the valid pulse on the next falling edge, while the result is stable. The hold checks drop the strobe and change the operands. One cycle later they confirm that the flags did not move and that no valid pulse appeared. The main sweep runs a 6-bit format over every operand pair in both NaN modes, and the expected order comes from the decoded numeric values.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

  typedef enum logic [1:0] {
    ORD_LT = 2'd0,
    ORD_EQ = 2'd1,
    ORD_GT = 2'd2,
    ORD_UN = 2'd3
  } ord_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
    logic ioc;
  } cmp_res_t;

  // Maps an ordering and the invalid indication onto the condition code
  function automatic cmp_res_t encode_flags(ord_e ord, logic ioc);
    cmp_res_t r;
    r = '0;
    r.ioc = ioc;
    unique case (ord)
      ORD_LT: r.n = 1'b1;
      ORD_EQ: begin r.z = 1'b1; r.c = 1'b1; end
      ORD_GT: r.c = 1'b1;
      ORD_UN: begin r.c = 1'b1; r.v = 1'b1; end
      default: r = '0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify #(
  parameter int EXP_W = 11,
  parameter int MAN_W = 52,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input  logic [W-1:0] word,
  output logic         is_nan,
  output logic         is_snan,
  output logic         is_zero
);
  logic [EXP_W-1:0] exp_f;
  logic [MAN_W-1:0] man_f;

  assign exp_f   = word[W-2 -: EXP_W];
  assign man_f   = word[MAN_W-1:0];
  assign is_nan  = (&exp_f) && (|man_f);
  assign is_snan = is_nan && !man_f[MAN_W-1];
  assign is_zero = ~|word[W-2:0];
endmodule

// File: rtl/fcmp_order.sv
module fcmp_order #(
  parameter int W = 64
) (
  input  logic         [W-1:0] lhs,
  input  logic         [W-1:0] rhs,
  input  logic                 lhs_zero,
  input  logic                 rhs_zero,
  output fcmp_pkg::ord_e       ord
);
  import fcmp_pkg::*;

  function automatic ord_e order_words(logic [W-1:0] a, logic [W-1:0] b,
                                       logic az, logic bz);
    logic mag_lt;
    if (a == b || (az && bz)) return ORD_EQ;
    if (a[W-1] != b[W-1]) return a[W-1] ? ORD_LT : ORD_GT;
    mag_lt = a[W-2:0] < b[W-2:0];
    if (a[W-1]) mag_lt = !mag_lt;
    return mag_lt ? ORD_LT : ORD_GT;
  endfunction

  assign ord = order_words(lhs, rhs, lhs_zero, rhs_zero);
endmodule

// File: rtl/fcmp_flag_unit.sv
module fcmp_flag_unit #(
  parameter int EXP_W = 11,
  parameter int MAN_W = 52,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] opd_a,
  input  logic [W-1:0] opd_b,
  input  logic         sig_qnan,
  input  logic         cmp_zero,
  output logic         out_valid,
  output logic         flag_n,
  output logic         flag_z,
  output logic         flag_c,
  output logic         flag_v,
  output logic         inv_op
);
  import fcmp_pkg::*;

  logic [W-1:0] sel_b;
  logic [W-1:0] opnd [2];
  logic [1:0]   nan_v, snan_v, zero_v, sig_v;
  logic         any_nan, any_sig;
  ord_e         num_ord, fin_ord;
  cmp_res_t     res_c, res_q;
  logic         vld_q;

  assign sel_b   = cmp_zero ? '0 : opd_b;
  assign opnd[0] = opd_a;
  assign opnd[1] = sel_b;

  for (genvar i = 0; i < 2; i++) begin : g_cls
    fcmp_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
      .word    (opnd[i]),
      .is_nan  (nan_v[i]),
      .is_snan (snan_v[i]),
      .is_zero (zero_v[i])
    );
    assign sig_v[i] = nan_v[i] && (snan_v[i] || sig_qnan);
  end

  assign any_nan = |nan_v;
  assign any_sig = |sig_v;

  fcmp_order #(.W(W)) u_ord (
    .lhs      (opd_a),
    .rhs      (sel_b),
    .lhs_zero (zero_v[0]),
    .rhs_zero (zero_v[1]),
    .ord      (num_ord)
  );

  assign fin_ord = any_nan ? ORD_UN : num_ord;
  assign res_c   = encode_flags(fin_ord, any_sig);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= in_valid;
      if (in_valid) res_q <= res_c;
    end
  end

  assign out_valid = vld_q;
  assign flag_n    = res_q.n;
  assign flag_z    = res_q.z;
  assign flag_c    = res_q.c;
  assign flag_v    = res_q.v;
  assign inv_op    = res_q.ioc;
endmodule

// File: rtl/fcmp_flag_unit_chk.sv
module fcmp_flag_unit_chk (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic sig_qnan,
  input logic any_nan,
  input logic out_valid,
  input logic flag_n,
  input logic flag_z,
  input logic flag_c,
  input logic flag_v,
  input logic inv_op
);
  assert_valid_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_no_spurious_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable({flag_n, flag_z, flag_c, flag_v, inv_op}));
  assert_unordered_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && any_nan) |=> (flag_c && flag_v && !flag_n && !flag_z));
  assert_quiet_signals_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && any_nan && sig_qnan) |=> inv_op);
  assert_no_ioc_ordered_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !any_nan) |=> !inv_op);
  assert_equal_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    flag_z |-> (flag_c && !flag_n && !flag_v));
  assert_less_alone_R5: assert property (@(posedge clk) disable iff (!rst_n)
    flag_n |-> ($countones({flag_z, flag_c, flag_v}) == 0));
endmodule

bind fcmp_flag_unit fcmp_flag_unit_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .sig_qnan  (sig_qnan),
  .any_nan   (any_nan),
  .out_valid (out_valid),
  .flag_n    (flag_n),
  .flag_z    (flag_z),
  .flag_c    (flag_c),
  .flag_v    (flag_v),
  .inv_op    (inv_op)
);

// File: tb/fcmp_flag_unit_bench.sv
`timescale 1ns/1ps
module fcmp_flag_unit_bench;
  localparam int SE = 3;
  localparam int SM = 2;
  localparam int SW = 1 + SE + SM;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Narrow format instance
  logic          iv, sq, cz;
  logic [SW-1:0] a, b;
  logic          ov, fn, fz, fc, fv, fi;

  fcmp_flag_unit #(.EXP_W(SE), .MAN_W(SM)) u_fcmp_flag_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(iv), .opd_a(a), .opd_b(b),
    .sig_qnan(sq), .cmp_zero(cz), .out_valid(ov), .flag_n(fn), .flag_z(fz),
    .flag_c(fc), .flag_v(fv), .inv_op(fi));

  // Full binary64 instance
  logic        div, dsq, dcz;
  logic [63:0] da, db;
  logic        dov, dn, dz, dc, dv, di;

  fcmp_flag_unit u_fcmp_flag_unit_dbl (
    .clk(clk), .rst_n(rst_n), .in_valid(div), .opd_a(da), .opd_b(db),
    .sig_qnan(dsq), .cmp_zero(dcz), .out_valid(dov), .flag_n(dn), .flag_z(dz),
    .flag_c(dc), .flag_v(dv), .inv_op(di));

  task automatic check(string tag, logic [5:0] act, logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  function automatic bit s_nan(logic [SW-1:0] x);
    return (x[SW-2 -: SE] == '1) && (x[SM-1:0] != 0);
  endfunction

  // Numeric value of a narrow word, with infinity mapped to a large number
  function automatic int s_val(logic [SW-1:0] x);
    int e, f, m;
    e = int'(x[SW-2 -: SE]);
    f = int'(x[SM-1:0]);
    if (e == 0) m = f;
    else if (e == (1 << SE) - 1) m = 100000;
    else m = ((1 << SM) + f) << (e - 1);
    return x[SW-1] ? -m : m;
  endfunction

  // Returns {valid, n, z, c, v, ioc}
  function automatic logic [5:0] s_expect(logic [SW-1:0] x, logic [SW-1:0] y,
                                          logic q, output string tag);
    bit nx, ny, ix;
    int vx, vy;
    nx = s_nan(x);
    ny = s_nan(y);
    if (nx || ny) begin
      ix = q || (nx && !x[SM-1]) || (ny && !y[SM-1]);
      tag = q ? "R3" : (ix ? "R2" : "R1");
      return {1'b1, 4'b0011, ix};
    end
    vx = s_val(x);
    vy = s_val(y);
    if (vx == vy) begin tag = "R4"; return 6'b101100; end
    tag = (x[SW-1] != y[SW-1]) ? "R5" : "R6";
    return (vx < vy) ? 6'b110000 : 6'b100100;
  endfunction

  task automatic s_run(logic [SW-1:0] x, logic [SW-1:0] y, logic q, logic z,
                       string pre);
    string tag;
    logic [5:0] exp;
    @(negedge clk);
    a = x; b = y; sq = q; cz = z; iv = 1'b1;
    exp = s_expect(x, z ? '0 : y, q, tag);
    @(negedge clk);
    iv = 1'b0;
    check({pre, tag}, {ov, fn, fz, fc, fv, fi}, exp);
  endtask

  task automatic d_run(logic [63:0] x, logic [63:0] y, logic q, logic z,
                       logic [5:0] exp, string tag);
    @(negedge clk);
    da = x; db = y; dsq = q; dcz = z; div = 1'b1;
    @(negedge clk);
    div = 1'b0;
    check(tag, {dov, dn, dz, dc, dv, di}, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R8 watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [5:0] prev;
    iv = 0; sq = 0; cz = 0; a = '0; b = '0;
    div = 0; dsq = 0; dcz = 0; da = '0; db = '0;
    repeat (3) @(negedge clk);
    check("R9 reset narrow", {ov, fn, fz, fc, fv, fi}, 6'b0);
    check("R9 reset wide", {dov, dn, dz, dc, dv, di}, 6'b0);
    rst_n = 1'b1;

    // Exhaustive narrow sweep in both NaN modes (R1-R6 tags come from s_expect)
    for (int q = 0; q < 2; q++)
      for (int i = 0; i < (1 << SW); i++)
        for (int j = 0; j < (1 << SW); j++)
          s_run(SW'(i), SW'(j), q[0], 1'b0, "sweep ");

    // R7: the right operand is replaced by +0 whatever it holds
    for (int i = 0; i < (1 << SW); i++) begin
      s_run(SW'(i), SW'(6'h3d), 1'b0, 1'b1, "R7 zero ");
      s_run(SW'(i), SW'(6'h22), 1'b1, 1'b1, "R7 zero q ");
    end

    // R8: hold without a strobe
    s_run(6'h08, 6'h04, 1'b0, 1'b0, "R8 setup ");
    prev = {1'b0, fn, fz, fc, fv, fi};
    @(negedge clk);
    a = 6'h3d; b = 6'h00; sq = 1'b1;
    @(negedge clk);
    check("R8 hold", {ov, fn, fz, fc, fv, fi}, prev);

    // Wide format directed checks
    d_run(64'h3FF0000000000000, 64'h4000000000000000, 0, 0, 6'b110000, "R6 1<2");
    d_run(64'hC000000000000000, 64'hBFF0000000000000, 0, 0, 6'b110000, "R6 -2<-1");
    d_run(64'hFFF0000000000000, 64'h7FF0000000000000, 0, 0, 6'b110000, "R5 -inf<+inf");
    d_run(64'h7FF0000000000000, 64'h7FEFFFFFFFFFFFFF, 0, 0, 6'b100100, "R6 inf>max");
    d_run(64'h8000000000000000, 64'h0000000000000000, 0, 0, 6'b101100, "R4 -0==+0");
    d_run(64'h0000000000000001, 64'h8000000000000001, 0, 0, 6'b100100, "R5 tiny");
    d_run(64'h7FF0000000000001, 64'h3FF0000000000000, 0, 0, 6'b100111, "R2 snan");
    d_run(64'h3FF0000000000000, 64'h7FF8000000000000, 0, 0, 6'b100110, "R1 qnan");
    d_run(64'h3FF0000000000000, 64'hFFF8000000000000, 1, 0, 6'b100111, "R3 qnan sig");
    d_run(64'h8000000000000000, 64'h7FF0000000000001, 0, 1, 6'b101100, "R7 -0 vs zero");
    d_run(64'hBFF0000000000000, 64'h0, 0, 1, 6'b110000, "R7 -1 vs zero");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule